// File: doc/BRIEF.md
# Fractional Clock Enable Divider

This block turns a fast system clock into a stream of single-cycle enable strobes. Logic that consumes the strobes treats each one as its own tick, so it steps at a slower rate while staying on the system clock. The spacing between strobes is a fixed-point ratio with a 16-bit whole part and an 8-bit fraction in steps of 1/256. Any ratio from 1.0 to 65536.0 can be set.

Firmware works out the ratio and writes it as one 32-bit word. A fractional ratio is built from periods of the whole part, with some periods one cycle longer. An 8-bit accumulator adds the fraction once per period. When it overflows, the next period gets one extra cycle, so the long-run average rate comes out exact. A restart input clears the phase and the accumulator. After a new ratio is loaded with a restart, the strobe pattern starts from a known point.

Top module: `fced_divider`

## Requirements
- R1: The ratio word keeps bits 31:16 as the whole part and bits 15:8 as the fraction (units of 1/256). Reading it back gives these fields as written, and bits 7:0 always read as zero. After reset the word reads 0x00010000.
- R2: With a whole part of 1 and a fraction of 0, `tick` is high on every system clock cycle. This includes the first cycles after reset.
- R3: With a whole part N of 2 or more and a zero fraction, `tick` is a single-cycle pulse every N cycles.
- R4: With whole part I and fraction F, the k-th tick after a restart falls in cycle k*I + floor((k-1)*F/256), counting from the cycle after the restart. Every period is therefore I or I+1 cycles, and the average period stays within one cycle of I + F/256.
- R5: A whole part of 0 stands for 65536. The fraction is then treated as 0, so the ratio is exactly 65536.0, the largest allowed.
- R6: Restart clears the phase. The first tick comes in cycle I after the restart. If a write happens in the same cycle as the restart, the phase uses the newly written ratio.
- R7: A write without a restart does not disturb the period already running. The new ratio applies from the period that begins at the next tick.
- R8: Bits 7:0 of a written word have no effect on the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the ratio word |
| cfg_wdata | input | 32 | Ratio word to write |
| cfg_rdata | output | 32 | Current ratio word, bits 7:0 zero |
| restart | input | 1 | Clears the divider phase and the fraction accumulator |
| tick | output | 1 | Single-cycle enable strobe |

## Verification
The embedded properties assume that `restart` and `cfg_we` are synchronous to `clk`. They also assume that a ratio change which must not be mixed with the old phase is followed by a restart. The gap and unity properties depend on the whole part held in the register. The stimulus therefore changes the ratio only at a restart, or just after a tick in the mid-period write case. Whole-part values cover 0, 1, 2, 3, 4 and 7. Fractions cover zero, one half, three quarters and a fraction that must be ignored. This keeps every expected tick inside the 200,000-cycle budget.

// File: rtl/fced_pkg.sv
package fced_pkg;
   localparam int unsigned REG_W_D  = 32;
   localparam int unsigned INT_W_D  = 16;
   localparam int unsigned FRAC_W_D = 8;
   localparam int unsigned RESET_INT = 1;

   typedef enum logic [1:0] {
      PH_HOLD_RESTART = 2'd0,
      PH_RELOAD       = 2'd1,
      PH_COUNT        = 2'd2
   } phase_op_e;
endpackage

// File: rtl/fced_ratio_reg.sv
module fced_ratio_reg #(
   parameter int unsigned REG_W  = fced_pkg::REG_W_D,
   parameter int unsigned INT_W  = fced_pkg::INT_W_D,
   parameter int unsigned FRAC_W = fced_pkg::FRAC_W_D,
   localparam int unsigned INT_LSB  = REG_W - INT_W,
   localparam int unsigned FRAC_LSB = INT_LSB - FRAC_W,
   localparam int unsigned CNT_W    = INT_W + 1,
   localparam int unsigned FW       = (FRAC_W > 0) ? FRAC_W : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic [CNT_W-1:0] run_int,
   output logic [FW-1:0]    run_frac,
   output logic [CNT_W-1:0] load_int,
   output logic [FW-1:0]    load_frac
);
   logic [INT_W-1:0] int_q;
   logic [FW-1:0]    frac_q;
   logic [INT_W-1:0] int_src;
   logic [FW-1:0]    frac_src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_q  <= INT_W'(fced_pkg::RESET_INT);
         frac_q <= '0;
      end else if (we) begin
         int_q  <= wdata[REG_W-1:INT_LSB];
         frac_q <= frac_src;
      end
   end

   assign int_src = we ? wdata[REG_W-1:INT_LSB] : int_q;

   generate
      if (FRAC_W > 0) begin : g_frac
         assign frac_src = we ? wdata[INT_LSB-1:FRAC_LSB] : frac_q;
      end else begin : g_nofrac
         assign frac_src = '0;
      end
      if (FRAC_LSB > 0) begin : g_low
         logic unused_low;
         assign unused_low = ^wdata[FRAC_LSB-1:0];
      end
      if (FRAC_W > 0 && FRAC_LSB > 0) begin : g_rd_full
         assign rdata = {int_q, frac_q, {FRAC_LSB{1'b0}}};
      end else if (FRAC_W > 0) begin : g_rd_nolow
         assign rdata = {int_q, frac_q};
      end else begin : g_rd_int
         assign rdata = {int_q, {INT_LSB{1'b0}}};
      end
   endgenerate

   // Whole part 0 stands for the largest ratio; fraction dropped there.
   always_comb begin
      run_int   = (int_q == '0)   ? CNT_W'(1) << INT_W : CNT_W'(int_q);
      run_frac  = (int_q == '0)   ? '0 : frac_q;
      load_int  = (int_src == '0) ? CNT_W'(1) << INT_W : CNT_W'(int_src);
      load_frac = (int_src == '0) ? '0 : frac_src;
   end

   generate
      if (INT_W + FRAC_W > REG_W) begin : g_bad_fields
         $error("fields wider than the ratio word");
      end
      if (INT_W < 1) begin : g_bad_int
         $error("whole part needs at least one bit");
      end
   endgenerate

   // R1: a written whole part reads back unchanged
   a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata[REG_W-1:INT_LSB] == $past(wdata[REG_W-1:INT_LSB]));
   // R5: a zero field always decodes to the top ratio
   a_r5_zero_is_max: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata[REG_W-1:INT_LSB] == '0) |-> (run_int[CNT_W-1] && run_frac == '0));
endmodule

// File: rtl/fced_frac_step.sv
module fced_frac_step #(
   parameter int unsigned FRAC_W = fced_pkg::FRAC_W_D,
   localparam int unsigned FW    = (FRAC_W > 0) ? FRAC_W : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          advance,
   input  logic [FW-1:0] frac,
   output logic          carry
);
   generate
      if (FRAC_W > 0) begin : g_acc
         logic [FW-1:0] acc_q;
         logic [FW:0]   sum;
         assign sum   = {1'b0, acc_q} + {1'b0, frac};
         assign carry = sum[FW];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       acc_q <= '0;
            else if (clear)   acc_q <= '0;
            else if (advance) acc_q <= sum[FW-1:0];
         end
      end else begin : g_none
         logic unused_in;
         assign unused_in = ^{clear, advance, frac};
         assign carry = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fced_phase.sv
module fced_phase #(
   parameter int unsigned INT_W  = fced_pkg::INT_W_D,
   parameter int unsigned FRAC_W = fced_pkg::FRAC_W_D,
   localparam int unsigned CNT_W = INT_W + 1,
   localparam int unsigned FW    = (FRAC_W > 0) ? FRAC_W : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] run_int,
   input  logic [FW-1:0]    run_frac,
   input  logic [CNT_W-1:0] load_int,
   output logic             tick
);
   import fced_pkg::*;

   logic [CNT_W-1:0] cnt_q;
   logic             carry;
   phase_op_e        op;

   assign tick = (cnt_q == CNT_W'(1));

   always_comb begin
      if (restart)   op = PH_HOLD_RESTART;
      else if (tick) op = PH_RELOAD;
      else           op = PH_COUNT;
   end

   fced_frac_step #(.FRAC_W(FRAC_W)) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (restart),
      .advance (op == PH_RELOAD),
      .frac    (run_frac),
      .carry   (carry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= CNT_W'(RESET_INT);
      else begin
         unique case (op)
            PH_HOLD_RESTART: cnt_q <= load_int;
            PH_RELOAD:       cnt_q <= run_int + CNT_W'(carry);
            default:         cnt_q <= cnt_q - CNT_W'(1);
         endcase
      end
   end

   // R4: the phase count never leaves 1 .. 2^INT_W + 1
   a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0 && cnt_q <= (CNT_W'(1) << INT_W) + CNT_W'(1));
   // R3: with a whole part above one, ticks never come back to back
   a_r3_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && run_int > CNT_W'(1)) |=> !tick);
   // R2: unity ratio keeps the strobe high
   a_r2_unity: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart && run_int == CNT_W'(1) && run_frac == '0) |=> tick);
   // R6: a restart to a ratio above one leaves the next cycle quiet
   a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && load_int > CNT_W'(1)) |=> !tick);
endmodule

// File: rtl/fced_divider.sv
module fced_divider #(
   parameter int unsigned REG_W  = fced_pkg::REG_W_D,
   parameter int unsigned INT_W  = fced_pkg::INT_W_D,
   parameter int unsigned FRAC_W = fced_pkg::FRAC_W_D,
   localparam int unsigned CNT_W = INT_W + 1,
   localparam int unsigned FW    = (FRAC_W > 0) ? FRAC_W : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             restart,
   output logic             tick
);
   logic [CNT_W-1:0] run_int;
   logic [CNT_W-1:0] load_int;
   logic [FW-1:0]    run_frac;
   logic [FW-1:0]    load_frac;
   logic             unused_load_frac;

   assign unused_load_frac = ^load_frac;

   fced_ratio_reg #(.REG_W(REG_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (cfg_we),
      .wdata     (cfg_wdata),
      .rdata     (cfg_rdata),
      .run_int   (run_int),
      .run_frac  (run_frac),
      .load_int  (load_int),
      .load_frac (load_frac)
   );

   fced_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .run_int  (run_int),
      .run_frac (run_frac),
      .load_int (load_int),
      .tick     (tick)
   );
endmodule

// File: tb/tb_fced_divider.sv
module tb_fced_divider;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        restart = 1'b0;
   logic        tick;

   int          n_checks = 0;
   int          n_fail = 0;
   longint      cyc = 0;
   longint      expq[$];
   string       tagq[$];
   bit          armed = 1'b0;
   longint      gate_cyc = 0;
   longint      first_tick = 0;
   longint      last_tick = 0;
   bit          seen_first = 1'b0;
   bit          done = 1'b0;

   fced_divider dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .restart   (restart),
      .tick      (tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string req, input bit ok, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Monitor: pops expected tick cycles and compares with the observed strobe
   always @(negedge clk) begin
      if (armed && cyc >= gate_cyc && expq.size() > 0) begin
         if (tick) begin
            check(tagq[0], cyc == expq[0], cyc, expq[0]);
            if (!seen_first) first_tick = cyc;
            seen_first = 1'b1;
            last_tick = cyc;
            void'(expq.pop_front());
            void'(tagq.pop_front());
         end else if (cyc > expq[0]) begin
            check(tagq[0], 1'b0, cyc, expq[0]);
            void'(expq.pop_front());
            void'(tagq.pop_front());
         end
         if (expq.size() == 0) armed = 1'b0;
      end
   end

   function automatic longint tick_at(longint k, longint wi, longint fr);
      return k * wi + ((k - 1) * fr) / 256;
   endfunction

   // Driver: writes a word, restarts, and queues the expected tick cycles
   task automatic play(input logic [31:0] word, input int nticks, input string req,
                       input bit same_cycle);
      longint wi;
      longint fr;
      longint c0;
      wi = (word[31:16] == 0) ? 65536 : longint'(word[31:16]);
      fr = (word[31:16] == 0) ? 0 : longint'(word[15:8]);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = word;
      if (!same_cycle) begin
         @(negedge clk);
         cfg_we = 1'b0;
      end
      restart = 1'b1;
      c0 = cyc + 1;
      seen_first = 1'b0;
      for (int k = 1; k <= nticks; k++) begin
         expq.push_back(c0 + tick_at(k, wi, fr) - 1);
         tagq.push_back(req);
      end
      gate_cyc = c0;
      armed = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      cfg_we = 1'b0;
      while (armed) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         check("watchdog", 1'b0, cyc, WATCHDOG);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      longint c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset value of the ratio word
      check("R1", cfg_rdata == 32'h0001_0000, cfg_rdata, 32'h0001_0000);
      // R2: unity ratio after reset strobes every cycle
      for (int i = 0; i < 4; i++) begin
         check("R2", tick == 1'b1, tick, 1);
         @(negedge clk);
      end

      // R2: unity ratio after restart
      play(32'h0001_0000, 20, "R2", 1'b0);
      // R3: integer ratios 2 and 3
      play(32'h0002_0000, 30, "R3", 1'b0);
      play(32'h0003_0000, 30, "R3", 1'b0);
      // R1: readback of fields
      @(negedge clk);
      check("R1", cfg_rdata == 32'h0003_0000, cfg_rdata, 32'h0003_0000);

      // R4: ratio 1.5 and a long window at 3.75
      play(32'h0001_8000, 40, "R4", 1'b0);
      play(32'h0003_C000, 200, "R4", 1'b0);
      // R4: average period over the window within one cycle of 3.75
      check("R4", ((last_tick - first_tick) * 256 - 199 * 960) <= 256 &&
                  ((last_tick - first_tick) * 256 - 199 * 960) >= -256,
            last_tick - first_tick, 199 * 960 / 256);

      // R8: low bits set must not change timing; R1: they read back zero
      play(32'h0002_00FF, 20, "R8", 1'b0);
      check("R1", cfg_rdata == 32'h0002_0000, cfg_rdata, 32'h0002_0000);
      check("R8", cfg_rdata[7:0] == 8'h00, cfg_rdata[7:0], 0);

      // R6: write in the same cycle as restart uses the new ratio
      play(32'h0004_4000, 20, "R6", 1'b1);
      check("R6", cfg_rdata == 32'h0004_4000, cfg_rdata, 32'h0004_4000);

      // R7: write without restart takes effect after the next tick
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = 32'h0004_0000;
      @(negedge clk);
      cfg_we = 1'b0;
      restart = 1'b1;
      c0 = cyc + 1;
      expq.push_back(c0 + 3);       tagq.push_back("R7");
      expq.push_back(c0 + 3 + 4);   tagq.push_back("R7");
      expq.push_back(c0 + 3 + 11);  tagq.push_back("R7");
      expq.push_back(c0 + 3 + 18);  tagq.push_back("R7");
      gate_cyc = c0;
      armed = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      while (expq.size() > 3) @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = 32'h0007_0000;
      @(negedge clk);
      cfg_we = 1'b0;
      while (armed) @(negedge clk);

      // R5: whole part zero is 65536, fraction ignored
      play(32'h0000_0000, 1, "R5", 1'b0);
      play(32'h0000_8000, 1, "R5", 1'b0);
      check("R5", cfg_rdata == 32'h0000_8000, cfg_rdata, 32'h0000_8000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule